// File: doc/BRIEF.md
# Correlation dump gather sequencer

This block gathers one complete correlation dump into a destination buffer. It collects data from four processing units and one system controller. A single start strobe launches the dump. The block then walks a fixed list of source regions, one 32-bit word at a time, through a simple read request/response port. Each word it reads is written to the next destination offset through a write port with backpressure. When the dump is complete, the block raises a one-cycle done pulse.

The list of regions is not stored anywhere. The block works it out from three configuration words per unit, which it samples when the dump starts. The low byte of each version word selects one of two field layouts. The decoded fields give the number of correlation blocks of that unit and the size of each block. The dump order is fixed:

- the four unit register windows,
- the system register window,
- every correlation block, taking units in ascending order.

Last, the system register window is read a second time. This copy lands on top of the first copy, so the buffer holds system state taken after the correlation data. The total dump size is presented while the dump runs, so a consumer can size or check the buffer.

Top module: `corl_dump_seq`

## Requirements
- R1: The dump reads and writes in this order: the register windows of units 0, 1, 2 and 3, then the system window, then the correlation blocks of unit 0, 1, 2 and 3 (block 0 first within a unit), then the system window again. Each written word equals the data returned for the read at the same position in the sequence.
- R2: Source byte addresses follow these rules:
  - Each register window is 128 bytes (32 words).
  - The window of unit n starts at base_addr + 0x400000 + n*0x80000.
  - Block j of unit n starts at that window start + 0x10000*(j+1).
  - The system window starts at 0xF0000000.
  - Within a region, words are read at consecutive 4-byte steps.
- R3: When the low byte of a unit's version word is 2 or more, the fields of that unit are:
  - correlator count in cfg_lo bits 7:4,
  - pack factor in cfg_lo bits 11:8,
  - lag count in cfg_lo bits 23:12,
  - metadata count in cfg_lo bits 30:24,
  - quantization counter count in cfg_hi bits 11:0.
- R4: When that low byte is below 2, the higher bits of the version word are ignored and the fields are:
  - pack factor fixed at 1,
  - correlator count in cfg_lo bits 7:4,
  - lag count in cfg_lo bits 19:8,
  - metadata count in cfg_lo bits 30:20,
  - quantization counter count in cfg_hi bits 11:0.
- R5: The block count of a unit is ceil(correlators / pack), and a pack factor of 0 is treated as 1. The block size in bytes is (pack*lags + meta + qcnt)*8. A unit with a block count of 0, or a block size of 0, contributes no reads.
- R6: Destination byte offsets run contiguously from 0 in dump order, 4 bytes per word. The second system window copy is written to offsets 512 to 639.
- R7: dump_bytes equals 640 plus, summed over all units, block count times block size. It is valid from the first clock edge after an accepted start.
- R8: Configuration words and base_addr are sampled only at a start that arrives while the block is idle. A start, or any change to the configuration inputs, during a running dump has no effect on that dump.
- R9: done is high for exactly one cycle: the cycle after the final write of the second system window copy is accepted.
- R10: The following hold at all times:
  - After reset, rd_req, wr_en and done are low.
  - rd_req and rd_addr hold until rd_ready.
  - wr_en, wr_addr and wr_data hold until wr_ready.
  - At most one read is outstanding: rd_req stays low from an accepted read until its rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, honoured only while idle |
| base_addr | input | 32 | Base byte address of the unit windows |
| cfg_ver | input | 128 | Version word per unit, unit n at bits 32n+31:32n |
| cfg_lo | input | 128 | First configuration word per unit |
| cfg_hi | input | 128 | Second configuration word per unit |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read byte address |
| rd_ready | input | 1 | Read request accepted this cycle |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| wr_en | output | 1 | Write request into the destination buffer |
| wr_addr | output | 32 | Destination byte offset |
| wr_data | output | 32 | Write data |
| wr_ready | input | 1 | Write accepted this cycle |
| done | output | 1 | One-cycle completion pulse |
| dump_bytes | output | 32 | Total dump size in bytes |

## Verification
The bench drives all inputs and reads all outputs on the falling clock edge, where every registered output has settled. It decides acceptance of a read or a write from the ready value it presents there, which the design then samples at the next rising edge.

Timing of each result:
- dump_bytes is compared one falling edge after the start pulse.
- Read data is returned no earlier than the falling edge after the request was accepted.
- done is expected at exactly the falling edge that follows the acceptance of the last expected write, and a done at any other falling edge is a failure.

Every read address and every write offset and data word is checked against a list that the bench builds arithmetically from the configuration.

// File: rtl/corl_dump_seq.sv
module corl_dump_seq #(
  parameter int          NUM_UNITS  = 4,
  parameter logic [31:0] SYS_BASE   = 32'hF000_0000,
  parameter logic [31:0] WIN_OFS    = 32'h0040_0000,
  parameter logic [31:0] WIN_STRIDE = 32'h0008_0000,
  parameter logic [31:0] BLK_STRIDE = 32'h0001_0000,
  parameter int          WIN_BYTES  = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [31:0]            base_addr,
  input  logic [NUM_UNITS*32-1:0] cfg_ver,
  input  logic [NUM_UNITS*32-1:0] cfg_lo,
  input  logic [NUM_UNITS*32-1:0] cfg_hi,
  output logic                   rd_req,
  output logic [31:0]            rd_addr,
  input  logic                   rd_ready,
  input  logic                   rd_valid,
  input  logic [31:0]            rd_data,
  output logic                   wr_en,
  output logic [31:0]            wr_addr,
  output logic [31:0]            wr_data,
  input  logic                   wr_ready,
  output logic                   done,
  output logic [31:0]            dump_bytes
);
  localparam int          UW        = $clog2(NUM_UNITS + 1);
  localparam logic [UW-1:0] SYS_IDX = UW'(NUM_UNITS);
  localparam logic [31:0] WINB      = 32'(WIN_BYTES);
  localparam logic [31:0] SYS_DST   = 32'(NUM_UNITS * WIN_BYTES);
  localparam logic [31:0] HDR_BYTES = 32'((NUM_UNITS + 1) * WIN_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT, S_WR} st_t;
  typedef enum logic [1:0] {K_REG, K_BLK, K_FIN} kind_t;

  st_t          st;
  kind_t        kind;
  logic [UW-1:0] idx;
  logic [3:0]   blk;
  logic [31:0]  off, dptr, data_q, base_q;
  logic [3:0]   nb_q  [NUM_UNITS];
  logic [31:0]  bsz_q [NUM_UNITS];

  logic [3:0]   dec_nb  [NUM_UNITS];
  logic [31:0]  dec_bsz [NUM_UNITS];

  generate
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_dec
      logic [31:0] v, a, b, wrd;
      logic        newf;
      logic [3:0]  pk;
      logic [11:0] lg, qc;
      logic [10:0] md;
      logic [4:0]  nbw;
      logic        unused_bits;
      assign v    = cfg_ver[u*32 +: 32];
      assign a    = cfg_lo[u*32 +: 32];
      assign b    = cfg_hi[u*32 +: 32];
      assign newf = v[7:0] >= 8'd2;
      assign pk   = (!newf || a[11:8] == 4'd0) ? 4'd1 : a[11:8];
      assign lg   = newf ? a[23:12] : a[19:8];
      assign md   = newf ? {4'd0, a[30:24]} : a[30:20];
      assign qc   = b[11:0];
      assign nbw  = ({1'b0, a[7:4]} + {1'b0, pk} - 5'd1) / {1'b0, pk};
      assign wrd  = 32'(pk) * 32'(lg) + 32'(md) + 32'(qc);
      assign dec_bsz[u] = {wrd[28:0], 3'b000};
      assign dec_nb[u]  = (wrd == 32'd0) ? 4'd0 : nbw[3:0];
      assign unused_bits = ^{v[31:8], a[31], a[3:0], b[31:12]};
    end
  endgenerate

  logic [31:0] tot;
  always_comb begin
    tot = HDR_BYTES;
    for (int u = 0; u < NUM_UNITS; u++)
      tot = tot + 32'(dec_nb[u]) * dec_bsz[u];
  end

  logic [3:0]  cur_nb;
  logic [31:0] cur_bsz;
  always_comb begin
    cur_nb  = '0;
    cur_bsz = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      if (idx == UW'(u)) begin
        cur_nb  = nb_q[u];
        cur_bsz = bsz_q[u];
      end
  end

  logic [UW-1:0] nxt;
  always_comb begin
    nxt = SYS_IDX;
    for (int u = NUM_UNITS - 1; u >= 0; u--)
      if (nb_q[u] != 4'd0 && (kind == K_REG || UW'(u) > idx)) nxt = UW'(u);
  end

  logic [31:0] win, seg_src, seg_len;
  logic        last_word;
  assign win = base_q + WIN_OFS + 32'(idx) * WIN_STRIDE;
  always_comb begin
    case (kind)
      K_REG:   seg_src = (idx == SYS_IDX) ? SYS_BASE : win;
      K_BLK:   seg_src = win + BLK_STRIDE * (32'(blk) + 32'd1);
      default: seg_src = SYS_BASE;
    endcase
  end
  assign seg_len   = (kind == K_BLK) ? cur_bsz : WINB;
  assign last_word = (off + 32'd4) >= seg_len;

  assign rd_req  = (st == S_RD);
  assign rd_addr = seg_src + off;
  assign wr_en   = (st == S_WR);
  assign wr_addr = dptr;
  assign wr_data = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      kind       <= K_REG;
      idx        <= '0;
      blk        <= '0;
      off        <= '0;
      dptr       <= '0;
      data_q     <= '0;
      base_q     <= '0;
      done       <= 1'b0;
      dump_bytes <= '0;
      for (int u = 0; u < NUM_UNITS; u++) begin
        nb_q[u]  <= '0;
        bsz_q[u] <= '0;
      end
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          for (int u = 0; u < NUM_UNITS; u++) begin
            nb_q[u]  <= dec_nb[u];
            bsz_q[u] <= dec_bsz[u];
          end
          base_q     <= base_addr;
          dump_bytes <= tot;
          kind       <= K_REG;
          idx        <= '0;
          blk        <= '0;
          off        <= '0;
          dptr       <= '0;
          st         <= S_RD;
        end
        S_RD:   if (rd_ready) st <= S_WAIT;
        S_WAIT: if (rd_valid) begin
          data_q <= rd_data;
          st     <= S_WR;
        end
        S_WR: if (wr_ready) begin
          st   <= S_RD;
          dptr <= dptr + 32'd4;
          off  <= off + 32'd4;
          if (last_word) begin
            off <= '0;
            case (kind)
              K_REG: begin
                if (idx < SYS_IDX) idx <= idx + 1'b1;
                else if (nxt != SYS_IDX) begin
                  kind <= K_BLK;
                  idx  <= nxt;
                  blk  <= '0;
                end else begin
                  kind <= K_FIN;
                  dptr <= SYS_DST;
                end
              end
              K_BLK: begin
                if (({1'b0, blk} + 5'd1) < {1'b0, cur_nb}) blk <= blk + 4'd1;
                else if (nxt != SYS_IDX) begin
                  idx <= nxt;
                  blk <= '0;
                end else begin
                  kind <= K_FIN;
                  dptr <= SYS_DST;
                end
              end
              default: begin
                st   <= S_IDLE;
                done <= 1'b1;
              end
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ready |=> rd_req && $stable(rd_addr));

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_ready |=> wr_en && $stable(wr_addr) && $stable(wr_data));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en && wr_ready));

  // R6
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < dump_bytes));

  // R8
  size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req || wr_en) && $past(rd_req || wr_en) |-> $stable(dump_bytes));
endmodule

// File: tb/corl_dump_seq_tb.sv
module corl_dump_seq_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0;
  logic [31:0] base = 32'h1000_0000;
  logic [31:0] cv [4], ca [4], cb [4];
  logic [127:0] cfg_ver, cfg_lo, cfg_hi;
  logic        rd_req, wr_en, done;
  logic [31:0] rd_addr, wr_addr, wr_data, dump_bytes;
  logic        rd_ready = 1'b0, rd_valid = 1'b0, wr_ready = 1'b0;
  logic [31:0] rd_data = '0;

  assign cfg_ver = {cv[3], cv[2], cv[1], cv[0]};
  assign cfg_lo  = {ca[3], ca[2], ca[1], ca[0]};
  assign cfg_hi  = {cb[3], cb[2], cb[1], cb[0]};

  corl_dump_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base),
    .cfg_ver(cfg_ver), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .done(done), .dump_bytes(dump_bytes)
  );

  int checks = 0, errors = 0, cyc = 0;
  int unsigned exp_src[$], exp_dst[$];
  logic [31:0] exp_bytes;
  int rd_idx, wr_idx, ndone, viol;
  bit bp = 0, pend = 0, done_due = 0;
  int dly = 0;
  logic [31:0] pend_addr = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dfun(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  task automatic dec(input logic [31:0] v, input logic [31:0] a, input logic [31:0] b,
                     output int nb, output int bsz);
    int c, p, l, m, q;
    c = int'((a >> 4) & 32'hF);
    q = int'(b & 32'hFFF);
    if ((v & 32'hFF) >= 32'd2) begin
      p = int'((a >> 8) & 32'hF);
      l = int'((a >> 12) & 32'hFFF);
      m = int'((a >> 24) & 32'h7F);
    end else begin
      p = 1;
      l = int'((a >> 8) & 32'hFFF);
      m = int'((a >> 20) & 32'h7FF);
    end
    if (p == 0) p = 1;
    bsz = (p * l + m + q) * 8;
    nb  = (bsz == 0) ? 0 : (c + p - 1) / p;
  endtask

  task automatic build();
    int nb, bsz;
    int unsigned d, w0;
    exp_src.delete();
    exp_dst.delete();
    exp_bytes = 32'd640;
    for (int n = 0; n < 4; n++)
      for (int w = 0; w < 32; w++) begin
        exp_src.push_back(base + 32'h40_0000 + n * 32'h8_0000 + 4 * w);
        exp_dst.push_back(128 * n + 4 * w);
      end
    for (int w = 0; w < 32; w++) begin
      exp_src.push_back(32'hF000_0000 + 4 * w);
      exp_dst.push_back(512 + 4 * w);
    end
    d = 640;
    for (int n = 0; n < 4; n++) begin
      dec(cv[n], ca[n], cb[n], nb, bsz);
      exp_bytes = exp_bytes + nb * bsz;
      for (int j = 0; j < nb; j++) begin
        w0 = base + 32'h40_0000 + n * 32'h8_0000 + 32'h1_0000 * (j + 1);
        for (int w = 0; w < bsz / 4; w++) begin
          exp_src.push_back(w0 + 4 * w);
          exp_dst.push_back(d);
          d += 4;
        end
      end
    end
    for (int w = 0; w < 32; w++) begin
      exp_src.push_back(32'hF000_0000 + 4 * w);
      exp_dst.push_back(512 + 4 * w);
    end
  endtask

  always @(negedge clk) begin
    bit pend0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rst_n) begin
      pend = 0;
      rd_valid = 1'b0;
    end else begin
      if (done_due) begin
        check({31'd0, done}, 32'd1, "R9 done after last write");
        if (done) ndone++;
        done_due = 0;
      end else if (done) begin
        check(32'd1, 32'd0, "R9 stray done");
      end
      pend0 = pend;
      rd_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          rd_valid = 1'b1;
          rd_data  = dfun(pend_addr);
          pend     = 0;
        end else dly--;
      end
      rd_ready = bp ? (lfsr[0] | lfsr[5]) : 1'b1;
      wr_ready = bp ? (lfsr[1] | lfsr[7]) : 1'b1;
      if (rd_req && pend0) viol++;
      if (rd_req && rd_ready) begin
        if (rd_idx < exp_src.size()) check(rd_addr, exp_src[rd_idx], "R2 read address");
        else check(rd_addr, 32'hFFFF_FFFF, "R1 extra read");
        rd_idx++;
        pend = 1;
        pend_addr = rd_addr;
        dly = bp ? int'(lfsr[3:2]) : 0;
      end
      if (wr_en && wr_ready) begin
        if (wr_idx < exp_dst.size()) begin
          check(wr_addr, exp_dst[wr_idx], "R6 write offset");
          check(wr_data, dfun(exp_src[wr_idx]), "R1 write data");
        end else check(wr_addr, 32'hFFFF_FFFF, "R1 extra write");
        wr_idx++;
        if (wr_idx == exp_dst.size()) done_due = 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      errors++;
      $display("FAIL watchdog R9: actual no completion expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic set_unit(input int u, input logic [31:0] v, input logic [31:0] a, input logic [31:0] b);
    cv[u] = v; ca[u] = a; cb[u] = b;
  endtask

  task automatic run_dump(input string tag, input bit disturb);
    build();
    rd_idx = 0; wr_idx = 0; ndone = 0; viol = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(dump_bytes, exp_bytes, "R7 dump size");
    if (disturb) begin
      repeat (20) @(negedge clk);
      base = 32'h3000_0000;
      set_unit(0, 32'd1, 32'h0010_2130, 32'd0);
      set_unit(1, 32'd1, 32'h0410_0420, 32'd0);
      set_unit(2, 32'd0, 32'h0000_0210, 32'd2);
      set_unit(3, 32'd1, 32'h0000_0000, 32'd0);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (5) @(negedge clk);
      check(dump_bytes, exp_bytes, "R8 size unchanged by late start");
    end
    while (ndone == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(wr_idx, exp_dst.size(), tag);
    check(rd_idx, exp_src.size(), "R1 read count");
    check(ndone, 1, "R9 one done pulse");
    check(viol, 0, "R10 single outstanding read");
  endtask

  initial begin
    for (int u = 0; u < 4; u++) set_unit(u, 32'd2, 32'd0, 32'd0);
    repeat (3) @(negedge clk);
    check({29'd0, rd_req, wr_en, done}, 32'd0, "R10 reset outputs");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({29'd0, rd_req, wr_en, done}, 32'd0, "R10 idle outputs");

    // R3: new layout, mixed counts
    set_unit(0, 32'd2, (32'd1 << 24) | (32'd2 << 12) | (32'd2 << 8) | (32'd3 << 4), 32'd1);
    set_unit(1, 32'd2, (32'd5 << 12), 32'd0);
    set_unit(2, 32'd2, (32'd1 << 12) | (32'd1 << 8) | (32'd5 << 4), 32'd0);
    set_unit(3, 32'd7, (32'd2 << 24) | (32'd1 << 12) | (32'd3 << 8) | (32'd1 << 4), 32'd3);
    run_dump("R3 new layout word count", 0);

    // R4: old layout with backpressure
    bp = 1;
    set_unit(0, 32'd1, (32'd1 << 20) | (32'h21 << 8) | (32'd3 << 4), 32'd0);
    set_unit(1, 32'd1, (32'h41 << 20) | (32'd4 << 8) | (32'd2 << 4), 32'd0);
    set_unit(2, 32'd0, (32'd2 << 8) | (32'd1 << 4), 32'd2);
    set_unit(3, 32'd1, 32'd0, 32'd0);
    run_dump("R4 old layout word count", 0);

    // R4: minor byte alone selects the layout
    set_unit(0, 32'h0305_0001, 32'h0200_3120, 32'd1);
    set_unit(1, 32'h0000_0102, 32'h0200_3120, 32'd1);
    set_unit(2, 32'hFF00_0000, 32'h0200_3120, 32'd1);
    set_unit(3, 32'h0000_00FF, 32'h0200_3120, 32'd1);
    run_dump("R4 minor version select word count", 0);

    // R5: zero counts, zero size, pack of zero
    base = 32'h0000_0000;
    set_unit(0, 32'd2, 32'h0000_1010, 32'd0);
    set_unit(1, 32'd2, 32'h0000_0240, 32'd0);
    set_unit(2, 32'd2, (32'd1 << 12) | (32'd2 << 4), 32'd0);
    set_unit(3, 32'd1, 32'h0000_0500, 32'd0);
    run_dump("R5 skipped units word count", 0);

    // R8: late start and config change ignored, then applied on next start
    base = 32'h2000_0000;
    set_unit(0, 32'd2, (32'd1 << 24) | (32'd2 << 12) | (32'd2 << 8) | (32'd3 << 4), 32'd1);
    set_unit(1, 32'd2, 32'd0, 32'd0);
    set_unit(2, 32'd2, (32'd1 << 12) | (32'd1 << 8) | (32'd2 << 4), 32'd0);
    set_unit(3, 32'd2, 32'd0, 32'd0);
    run_dump("R8 disturbed dump word count", 1);
    run_dump("R8 next dump uses new config", 0);

    // R5: sweep of correlator count and pack factor on unit 1
    bp = 0;
    base = 32'h1000_0000;
    for (int pi = 0; pi < 5; pi++) begin
      int p;
      p = (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? 2 : (pi == 3) ? 5 : 15;
      for (int c = 0; c < 16; c++) begin
        set_unit(0, 32'd2, 32'd0, 32'd0);
        set_unit(1, 32'd2, (32'd1 << 12) | (32'(p) << 8) | (32'(c) << 4), 32'd0);
        set_unit(2, 32'd2, 32'd0, 32'd0);
        set_unit(3, 32'd2, 32'd0, 32'd0);
        run_dump("R5 sweep word count", 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule